// File: doc/BRIEF.md
# Serial Configuration Stream Loader with Chain Forwarding

This block is the master end of a serial configuration link. On a start request it pulses a reset line to an external serial memory, then generates a configuration clock at half the system clock rate. The memory moves to its next bit on every rising edge of that clock. The loader takes one bit per rising edge. It checks a fixed preamble and reads a 24-bit count of the payload bits that follow for the whole chain. It keeps the first `SHARE_BITS` payload bits as its own share.

Every header bit, and every payload bit past the share, is re-driven on a serial chain output for the next device. The output changes on the falling edge right after the bit was taken, which is one and a half clock periods after the memory presented it. The next device can therefore sample it on the following rising edge. A load-in-progress line is low for the whole load. The memory enable follows either that line or the done flag, chosen by a parameter, and a second parameter raises done early at the end of the own share. A wrong preamble bit, or a chain count smaller than the share, raises an error and stops the clock.

Top module: `cfg_serial_loader`

## Requirements
- R1: A start request taken while the block is idle, done or failed drives `mem_rst_n` low for exactly `RST_CYC` system cycles and drives `ldc_n` low. `ldc_n` stays low until the load finishes or fails and is high at all other times, including after reset.
- R2: While loading, `cclk` toggles on every system clock edge. The first edge after the reset pulse raises it, so one period is two system cycles. `cclk` is low whenever `ldc_n` is high or `mem_rst_n` is low.
- R3: One `sdin` bit is taken at each system edge that raises `cclk`. The first 8 bits must equal the preamble 8'hB5, most significant bit first. The next 24 bits are the payload bit count, most significant bit first. The payload bits follow.
- R4: The first `SHARE_BITS` payload bits are collected in `share`, with the first bit received ending up in the most significant position. `share` is cleared at a start and then keeps its value until the next start.
- R5: `dout` changes only at a system edge that drops `cclk`. At the fall right after a bit is taken, `dout` takes that bit if it is a header bit or a payload bit past the share, and takes 1 otherwise. So a downstream device sampling at each rising `cclk` sees 1, then one value per streamed bit.
- R6: After the last payload bit is taken, `cclk` runs one more full period without taking a bit, so that the last forwarded bit is clocked downstream. It then stops low and `dout` returns to 1.
- R7: With `EARLY_DONE`=0, `done` rises when the whole chain has been loaded, at the same edge that raises `ldc_n`. With `EARLY_DONE`=1, `done` rises at the edge that takes the last share bit, while loading goes on. `done` is cleared only by a start.
- R8: With `CE_FROM_DONE`=0, `mem_ce_n` equals `ldc_n`. With `CE_FROM_DONE`=1, `mem_ce_n` equals `done`.
- R9: A preamble bit that does not match sets `err` at the edge that takes it. No further rising `cclk` follows, and `ldc_n` goes high. `err` holds until the next start.
- R10: A payload bit count smaller than `SHARE_BITS` sets `err` at the edge that takes the last count bit, with the same stopping behaviour as R9.
- R11: A start request during the reset pulse, the load or the final period has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a load |
| sdin | input | 1 | Serial data from the external memory |
| cclk | output | 1 | Generated configuration clock |
| mem_rst_n | output | 1 | Active-low reset of the memory address pointer |
| mem_ce_n | output | 1 | Active-low memory enable |
| ldc_n | output | 1 | Low while a load is in progress |
| done | output | 1 | Load complete (whole chain or own share) |
| err | output | 1 | Bad preamble or count too small |
| dout | output | 1 | Serial chain output to the next device |
| share | output | SHARE_BITS | Captured own share of the payload |

## Verification
The bound checker watches, on every cycle, the rules that hold at any moment. The chain output may move only on a falling clock, the clock stays quiet outside a load and during the memory reset pulse, error and done hold until a start, the share does not move once done is high, and a running load never re-enters the reset pulse. The exact cycle of each clock edge, the content of the share, the bit order seen downstream, the extra flush period, and the point where early done rises can only be shown by the bench. It does this with its streamed frames, a behavioural memory and a per-cycle reference model.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_LOAD,
      ST_FLUSH,
      ST_DONE,
      ST_FAIL
   } ld_state_t;
endpackage

// File: rtl/cfg_cclk_gen.sv
// Half-rate configuration clock with edge strobes for the controller.
module cfg_cclk_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic kill,
   output logic cclk,
   output logic rise,
   output logic fall
);
   logic cclk_q;

   assign rise = en & ~cclk_q;
   assign fall = en & cclk_q;
   assign cclk = cclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cclk_q <= 1'b0;
      end else if (cclk_q) begin
         cclk_q <= 1'b0;
      end else begin
         cclk_q <= en & ~kill;
      end
   end
endmodule

// File: rtl/cfg_frame_parser.sv
// Header check, payload counting and own-share capture.
module cfg_frame_parser #(
   parameter int PRE_BITS = 8,
   parameter logic [PRE_BITS-1:0] PRE_PAT = 8'hB5,
   parameter int LEN_W = 24,
   parameter int SHARE_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  smp,
   input  logic                  sdin,
   output logic                  pre_bad,
   output logic                  len_bad,
   output logic                  share_last,
   output logic                  chain_last,
   output logic                  fwd_this,
   output logic [SHARE_BITS-1:0] share
);
   localparam int HDR  = PRE_BITS + LEN_W;
   localparam int HC_W = $clog2(HDR + 1);
   localparam logic [HC_W-1:0]  HC_PRE  = HC_W'(PRE_BITS);
   localparam logic [HC_W-1:0]  HC_HDR  = HC_W'(HDR);
   localparam logic [HC_W-1:0]  HC_LAST = HC_W'(HDR - 1);
   localparam logic [LEN_W-1:0] SHARE_L = LEN_W'(SHARE_BITS);

   logic [HC_W-1:0]       hdr_cnt;
   logic [PRE_BITS-1:0]   pat_q;
   logic [LEN_W-1:0]      len_q;
   logic [LEN_W-1:0]      pay_cnt;
   logic [SHARE_BITS-1:0] share_q;
   logic                  in_pre, in_hdr, in_len, in_share;
   logic [LEN_W-1:0]      len_nxt;

   always_comb begin
      in_pre     = hdr_cnt < HC_PRE;
      in_hdr     = hdr_cnt < HC_HDR;
      in_len     = in_hdr & ~in_pre;
      in_share   = ~in_hdr & (pay_cnt < SHARE_L);
      len_nxt    = {len_q[LEN_W-2:0], sdin};
      pre_bad    = smp & in_pre & (sdin != pat_q[PRE_BITS-1]);
      len_bad    = smp & (hdr_cnt == HC_LAST) & (len_nxt < SHARE_L);
      share_last = smp & ~in_hdr & (pay_cnt == SHARE_L - 1'b1);
      chain_last = smp & ~in_hdr & (pay_cnt == len_q - 1'b1);
      fwd_this   = in_hdr | ~in_share;
   end

   assign share = share_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_cnt <= '0;
         pat_q   <= PRE_PAT;
         len_q   <= '0;
         pay_cnt <= '0;
         share_q <= '0;
      end else if (clear) begin
         hdr_cnt <= '0;
         pat_q   <= PRE_PAT;
         len_q   <= '0;
         pay_cnt <= '0;
         share_q <= '0;
      end else if (smp) begin
         if (in_hdr) hdr_cnt <= hdr_cnt + 1'b1;
         if (in_pre) pat_q <= {pat_q[PRE_BITS-2:0], 1'b0};
         if (in_len) len_q <= len_nxt;
         if (!in_hdr) pay_cnt <= pay_cnt + 1'b1;
         if (in_share) share_q <= {share_q[SHARE_BITS-2:0], sdin};
      end
   end
endmodule

// File: rtl/cfg_chain_fwd.sv
// Chain output stage: take at the rising strobe, drive at the next falling strobe.
module cfg_chain_fwd (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic rise,
   input  logic fall,
   input  logic smp,
   input  logic bit_in,
   input  logic fwd_in,
   output logic dout
);
   logic fb_q, fe_q, dout_q;

   assign dout = dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_q   <= 1'b1;
         fe_q   <= 1'b0;
         dout_q <= 1'b1;
      end else if (clear) begin
         fe_q <= 1'b0;
      end else if (rise) begin
         fb_q <= bit_in;
         fe_q <= smp & fwd_in;
      end else if (fall) begin
         dout_q <= fe_q ? fb_q : 1'b1;
      end
   end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
   parameter int PRE_BITS = 8,
   parameter logic [PRE_BITS-1:0] PRE_PAT = 8'hB5,
   parameter int LEN_W = 24,
   parameter int SHARE_BITS = 16,
   parameter int RST_CYC = 4,
   parameter bit EARLY_DONE = 1'b0,
   parameter bit CE_FROM_DONE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  sdin,
   output logic                  cclk,
   output logic                  mem_rst_n,
   output logic                  mem_ce_n,
   output logic                  ldc_n,
   output logic                  done,
   output logic                  err,
   output logic                  dout,
   output logic [SHARE_BITS-1:0] share
);
   import cfg_ld_pkg::*;

   localparam int RC_W = $clog2(RST_CYC + 1);
   localparam logic [RC_W-1:0] RC_END = RC_W'(RST_CYC - 1);

   if (PRE_BITS < 2) begin : g_chk_pre
      $error("PRE_BITS must be at least 2");
   end
   if (LEN_W < 2 || LEN_W > 31) begin : g_chk_len
      $error("LEN_W must lie in 2..31");
   end
   if (SHARE_BITS < 2 || SHARE_BITS > 4096) begin : g_chk_share
      $error("SHARE_BITS must lie in 2..4096");
   end
   if (RST_CYC < 1) begin : g_chk_rst
      $error("RST_CYC must be at least 1");
   end

   ld_state_t       state;
   logic [RC_W-1:0] rcnt;
   logic            fl_seen, done_q, err_q;
   logic            active, can_go, start_go;
   logic            rise, fall, smp, abort;
   logic            pre_bad, len_bad, share_last, chain_last, fwd_this;
   logic            done_set, ldc_n_w;

   assign active   = (state == ST_LOAD) | (state == ST_FLUSH);
   assign can_go   = (state == ST_IDLE) | (state == ST_DONE) | (state == ST_FAIL);
   assign start_go = start & can_go;
   assign smp      = rise & (state == ST_LOAD);
   assign abort    = pre_bad | len_bad;

   cfg_cclk_gen u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (active),
      .kill (abort),
      .cclk (cclk),
      .rise (rise),
      .fall (fall)
   );

   cfg_frame_parser #(
      .PRE_BITS  (PRE_BITS),
      .PRE_PAT   (PRE_PAT),
      .LEN_W     (LEN_W),
      .SHARE_BITS(SHARE_BITS)
   ) u_parse (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_go),
      .smp       (smp),
      .sdin      (sdin),
      .pre_bad   (pre_bad),
      .len_bad   (len_bad),
      .share_last(share_last),
      .chain_last(chain_last),
      .fwd_this  (fwd_this),
      .share     (share)
   );

   cfg_chain_fwd u_fwd (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_go),
      .rise  (rise),
      .fall  (fall),
      .smp   (smp),
      .bit_in(sdin),
      .fwd_in(fwd_this),
      .dout  (dout)
   );

   if (EARLY_DONE) begin : g_done_early
      assign done_set = share_last & ~abort;
   end else begin : g_done_chain
      assign done_set = (state == ST_FLUSH) & fall & fl_seen;
   end

   assign ldc_n_w   = ~((state == ST_RST) | active);
   assign ldc_n     = ldc_n_w;
   assign mem_rst_n = (state != ST_RST);
   assign done      = done_q;
   assign err       = err_q;

   if (CE_FROM_DONE) begin : g_ce_done
      assign mem_ce_n = done_q;
   end else begin : g_ce_ldc
      assign mem_ce_n = ldc_n_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         rcnt    <= '0;
         fl_seen <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
               if (start_go) begin
                  state   <= ST_RST;
                  rcnt    <= '0;
                  fl_seen <= 1'b0;
                  err_q   <= 1'b0;
               end
            end
            ST_RST: begin
               if (rcnt == RC_END) state <= ST_LOAD;
               else rcnt <= rcnt + 1'b1;
            end
            ST_LOAD: begin
               if (abort) begin
                  state <= ST_FAIL;
                  err_q <= 1'b1;
               end else if (chain_last) begin
                  state <= ST_FLUSH;
               end
            end
            ST_FLUSH: begin
               if (rise) fl_seen <= 1'b1;
               if (fall && fl_seen) state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else if (start_go) done_q <= 1'b0;
      else if (done_set) done_q <= 1'b1;
   end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int SHARE_BITS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  cclk,
   input logic                  mem_rst_n,
   input logic                  ldc_n,
   input logic                  done,
   input logic                  err,
   input logic                  dout,
   input logic [SHARE_BITS-1:0] share
);
   p_rst_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rst_n |-> (!ldc_n && !cclk));

   p_cclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ldc_n |-> !cclk);

   p_share_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(share));

   p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dout != $past(dout)) |-> ($past(cclk) && !cclk));

   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (ldc_n && !cclk));

   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);

   p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ldc_n && mem_rst_n) |=> mem_rst_n);
endmodule

bind cfg_serial_loader cfg_loader_chk #(.SHARE_BITS(SHARE_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .cclk     (cclk),
   .mem_rst_n(mem_rst_n),
   .ldc_n    (ldc_n),
   .done     (done),
   .err      (err),
   .dout     (dout),
   .share    (share)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
   localparam int CLK_P = 10;
   localparam int RSTC  = 4;
   localparam int SHB   = 16;
   localparam logic [7:0] PRE = 8'hB5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic start_e = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   // main instance
   logic sdin, cclk, mem_rst_n, mem_ce_n, ldc_n, done, err, dout;
   logic [SHB-1:0] share;
   logic mem_u [0:127];
   int   addr_u = 0;

   cfg_serial_loader uut (
      .clk(clk), .rst_n(rst_n), .start(start), .sdin(sdin),
      .cclk(cclk), .mem_rst_n(mem_rst_n), .mem_ce_n(mem_ce_n),
      .ldc_n(ldc_n), .done(done), .err(err), .dout(dout), .share(share)
   );

   always @(posedge cclk or negedge mem_rst_n)
      if (!mem_rst_n) addr_u <= 0;
      else if (!mem_ce_n) addr_u <= addr_u + 1;
   assign sdin = mem_u[addr_u];

   // early-done instance, enable driven from done
   logic sdin_e, cclk_e, mem_rst_n_e, mem_ce_n_e, ldc_n_e, done_e, err_e, dout_e;
   logic [SHB-1:0] share_e;
   logic mem_e [0:127];
   int   addr_e = 0;
   int   rises_e = 0;

   cfg_serial_loader #(.EARLY_DONE(1'b1), .CE_FROM_DONE(1'b1)) uut_e (
      .clk(clk), .rst_n(rst_n), .start(start_e), .sdin(sdin_e),
      .cclk(cclk_e), .mem_rst_n(mem_rst_n_e), .mem_ce_n(mem_ce_n_e),
      .ldc_n(ldc_n_e), .done(done_e), .err(err_e), .dout(dout_e), .share(share_e)
   );

   always @(posedge cclk_e or negedge mem_rst_n_e)
      if (!mem_rst_n_e) addr_e <= 0;
      else if (!mem_ce_n_e) addr_e <= addr_e + 1;
   assign sdin_e = mem_e[addr_e];
   always @(posedge cclk_e) rises_e <= rises_e + 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // downstream capture at every rising cclk
   bit   cap_on = 1'b0;
   logic ds_q[$];
   always @(posedge cclk) if (cap_on) ds_q.push_back(dout);

   // behavioural reference model, advanced once per cycle
   int   ms = 0;        // 0 idle 1 reset 2 load 3 flush 4 done 5 fail
   int   mcnt = 0, midx = 0, mlen = 0;
   logic mcclk = 0, mdout = 1, mdone = 0, merr = 0, mfb = 1, mfe = 0, mfl = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cclk == mcclk, (ms == 3) ? "R6 cclk" : "R2 cclk", cclk, mcclk);
         chk(dout == mdout, "R5 dout", dout, mdout);
         chk(done == mdone, "R7 done", done, mdone);
         chk(err == merr, "R9/R10 err", err, merr);
         chk(ldc_n == !(ms >= 1 && ms <= 3), "R1 ldc_n", ldc_n, !(ms >= 1 && ms <= 3));
         chk(mem_rst_n == (ms != 1), "R1 mem_rst_n", mem_rst_n, ms != 1);
         chk(mem_ce_n == ldc_n, "R8 mem_ce_n", mem_ce_n, ldc_n);
      end
      if (!rst_n) begin
         ms = 0; mcnt = 0; midx = 0; mlen = 0;
         mcclk = 0; mdout = 1; mdone = 0; merr = 0; mfb = 1; mfe = 0; mfl = 0;
      end else begin
         case (ms)
            0, 4, 5: if (start) begin
               ms = 1; mcnt = 0; midx = 0; mlen = 0;
               mdone = 0; merr = 0; mfe = 0; mfl = 0; mcclk = 0;
            end
            1: if (mcnt == RSTC - 1) ms = 2; else mcnt++;
            2: if (!mcclk) begin
               bit b, bad;
               int p;
               b = sdin; bad = 0; p = midx - 32;
               if (midx < 8) bad = (b != PRE[7-midx]);
               else if (midx < 32) begin
                  mlen = mlen * 2 + int'(b);
                  if (midx == 31 && mlen < SHB) bad = 1;
               end
               if (bad) begin
                  ms = 5; merr = 1;
               end else begin
                  mfb = b;
                  mfe = (midx < 32) || (p >= SHB);
                  if (midx >= 32 && p == mlen - 1) ms = 3;
                  midx++;
                  mcclk = 1;
               end
            end else begin
               mcclk = 0; mdout = mfe ? mfb : 1'b1;
            end
            3: if (!mcclk) begin
               mcclk = 1; mfe = 0; mfl = 1;
            end else begin
               mcclk = 0; mdout = mfe ? mfb : 1'b1;
               if (mfl) begin ms = 4; mdone = 1; end
            end
            default: ms = 0;
         endcase
      end
   end

   function automatic logic pay_bit(input int i, input int seed);
      return ((i * 5 + seed) % 7) < 3;
   endfunction

   function automatic logic frame_bit(input int i, input int len, input bit bad, input int seed);
      logic b;
      if (i < 8) begin
         b = PRE[7-i];
         if (bad && i == 3) b = ~b;
      end else if (i < 32) b = 1'((len >> (31 - i)) & 1);
      else b = pay_bit(i - 32, seed);
      return b;
   endfunction

   task automatic pulse(ref logic s);
      @(posedge clk); #1 s = 1'b1;
      @(posedge clk); #1 s = 1'b0;
   endtask

   task automatic run_load(input int len, input bit bad, input int seed, input bit exp_err, input bit poke);
      logic [SHB-1:0] exp_sh;
      int nb;
      nb = 32 + len;
      for (int i = 0; i < 128; i++) mem_u[i] = (i < nb) ? frame_bit(i, len, bad, seed) : 1'b1;
      ds_q.delete();
      cap_on = 1'b1;
      pulse(start);
      if (poke) begin
         repeat (30) @(posedge clk);
         pulse(start);                      // R11: ignored mid-load
      end
      @(posedge clk);
      while (!ldc_n) @(posedge clk);
      repeat (3) @(posedge clk);
      cap_on = 1'b0;
      @(negedge clk);
      chk(err == exp_err, "R9/R10 final err", err, exp_err);
      chk(cclk == 1'b0, "R2 cclk stopped", cclk, 0);
      if (!exp_err) begin
         exp_sh = '0;
         for (int i = 0; i < SHB; i++) exp_sh = {exp_sh[SHB-2:0], pay_bit(i, seed)};
         chk(share == exp_sh, "R3 R4 share", share, exp_sh);
         chk(done == 1'b1, "R7 done at end", done, 1);
         chk(dout == 1'b1, "R6 dout idle", dout, 1);
         chk(ds_q.size() == nb + 1, "R5 R6 downstream count", ds_q.size(), nb + 1);
         if (ds_q.size() == nb + 1) begin
            for (int k = 0; k <= nb; k++) begin
               logic e;
               if (k == 0) e = 1'b1;
               else if ((k - 1) < 32 || (k - 1 - 32) >= SHB) e = mem_u[k-1];
               else e = 1'b1;
               chk(ds_q[k] == e, "R5 downstream bit", ds_q[k], e);
            end
         end
      end else begin
         chk(done == 1'b0, "R9 no done after error", done, 0);
      end
   endtask

   int  seen_e = 0;
   always @(negedge clk) if (rst_n) begin
      chk(mem_ce_n_e == done_e, "R8 enable from done", mem_ce_n_e, done_e);
      if (done_e && seen_e == 0) begin
         seen_e = 1;
         chk(rises_e == 32 + SHB, "R7 early done edge", rises_e, 32 + SHB);
         chk(ldc_n_e == 1'b0, "R7 early done while loading", ldc_n_e, 0);
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) begin mem_u[i] = 1'b1; mem_e[i] = 1'b1; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(ldc_n && mem_rst_n && !cclk && !done && !err && dout, "R1 reset state",
          {ldc_n, mem_rst_n, cclk, done, err, dout}, 6'b110001);
      run_load(40, 1'b0, 1, 1'b0, 1'b1);   // normal chain with a tail
      run_load(40, 1'b1, 2, 1'b1, 1'b0);   // preamble mismatch, R9
      run_load(10, 1'b0, 3, 1'b1, 1'b0);   // count below share, R10
      run_load(16, 1'b0, 4, 1'b0, 1'b0);   // exactly the share, no tail
      run_load(23, 1'b0, 5, 1'b0, 1'b0);   // short tail after a restart
      for (int i = 0; i < 128; i++) mem_e[i] = (i < 72) ? frame_bit(i, 40, 1'b0, 6) : 1'b1;
      rises_e = 0;
      pulse(start_e);
      repeat (200) @(posedge clk);
      @(negedge clk);
      chk(seen_e == 1, "R7 early done seen", seen_e, 1);
      begin
         logic [SHB-1:0] es;
         es = '0;
         for (int i = 0; i < SHB; i++) es = {es[SHB-2:0], pay_bit(i, 6)};
         chk(share_e == es, "R4 early share", share_e, es);
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule